// File: doc/BRIEF.md
# Network controller bring-up sequencer

This block takes an external Ethernet controller chip from reset to normal operation. It drives the chip's active-low reset line and watches the chip's active-low interrupt request line. It also issues the configuration register writes over a simple request/acknowledge write port. When the last configuration write has been accepted, it raises a ready flag.

The sequence runs once when the block leaves its own reset. It runs again only when the host sends a start pulse, because a full bring-up takes the link out of service for its whole length. The steps are:

1. Hold the chip in reset for a set number of cycles, then release it.
2. Wait for an oscillator-ready interrupt.
3. Wait for a self-initialization-done interrupt.
4. Play out a parameter table of register writes. The table is split into five stages: interrupt mask, physical layer, link/activity LEDs, MAC, and receive filter.

If either interrupt does not arrive within a bounded time, the block stops with a sticky error flag.

Top module: `nic_init_seq`

## Requirements
- R1: While the block's own reset is asserted, `chip_rst_n_o` is 0, `busy_o` is 1, and `ready_o`, `err_o` and `req_o` are 0.
- R2: After the block leaves reset, or after a start pulse is taken, `chip_rst_n_o` stays low for exactly `RST_HOLD` cycles and then goes high.
- R3: Once the reset line is high, the block waits for two separate interrupt events. An event is a falling edge of `irq_n_i`. The first event is the oscillator-ready event and the second is the self-initialization event. Events that occur while the reset line is low are ignored. No write request is made before the second event.
- R4: Each interrupt wait lasts at most `IRQ_TMO` cycles. On expiry, `err_o` goes to 1 and `busy_o` and `ready_o` go to 0. The reset line stays high and no write is issued.
- R5: After the second event, every table entry is written in index order, starting at entry 0. Entry i occupies bits [25i+24:25i] of `TABLE` and is packed as {last[24], addr[23:16], data[15:0]}. An entry with last=1 closes a stage. The five stages, in order, are: mask, physical layer, LEDs, MAC, and receive filter.
- R6: `req_o` stays high, with `addr_o` and `data_o` held stable, until `ack_i` is sampled high. After each acknowledge, `req_o` is low for at least one cycle.
- R7: `ready_o` rises in the cycle after the acknowledge of the entry that closes the fifth stage, and `busy_o` falls in that same cycle. Before that point `ready_o` is 0. It then stays at 1, and ignores interrupt activity, until the next start pulse.
- R8: A start pulse taken in any state restarts the sequence from R2. It clears `ready_o` and `err_o`, withdraws any pending request, and makes the next write start again at entry 0.
- R9: `err_o` remains set through later interrupt activity, with no writes issued, until a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; bring-up begins when it is released |
| start_i | input | 1 | One-cycle reinitialization command from the host |
| irq_n_i | input | 1 | Active-low interrupt request from the controller chip |
| ack_i | input | 1 | Write acknowledge; one cycle high accepts the current request |
| chip_rst_n_o | output | 1 | Active-low reset line to the controller chip |
| req_o | output | 1 | Write request |
| addr_o | output | AW | Register address of the current write |
| data_o | output | DW | Register data of the current write |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Controller fully configured |
| err_o | output | 1 | Sticky interrupt-timeout error |

## Verification
A wrong internal state shows up at the ports within one write handshake or one interrupt wait. A step skipped or repeated shows as a write with a wrong address or data, or a write at the wrong position in the logged order. An interrupt wait that advances too early shows as a request before the second interrupt pulse, and one that never advances shows as a timeout error. The bench logs every accepted write against a table decoded independently of the RTL. It checks ready against the final acknowledge, and measures the reset-line low time cycle by cycle, under random interrupt spacing and random acknowledge delays.

// File: rtl/nbs_pkg.sv
// nbs_pkg: shared types for the network controller bring-up sequencer.
// Assumes: five configuration stages, fixed in order by the write table.
package nbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_REL,
        ST_WOSC,
        ST_WSELF,
        ST_CFG,
        ST_DONE
    } nbs_state_t;

    localparam int unsigned NBS_STAGES = 5;
endpackage

// File: rtl/nbs_irq_edge.sv
// nbs_irq_edge: two-flop synchronizer for the chip's active-low interrupt,
// plus a falling-edge detector that gives a one-cycle event pulse.
// Assumes: the interrupt line is asynchronous and is held low for at least
// two clock cycles.
module nbs_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    output logic evt_o
);
    logic s1_q, s2_q, prev_q;

    // Synchronize the line and keep one cycle of history for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= irq_n_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign evt_o = prev_q & ~s2_q;

    // R3: one falling edge gives exactly one event.
    a_r3_single_evt: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
endmodule

// File: rtl/nbs_tmr.sv
// nbs_tmr: loadable countdown timer that stops at zero. One instance serves
// both the reset-hold window and the interrupt timeouts.
// Assumes: RST_VAL fits in W bits.
module nbs_tmr #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load has priority; counting down stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= W'(RST_VAL);
        else if (load)                   cnt_q <= load_val;
        else if (dec && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R4: a decrement that is not a reload always lowers the count by one.
    a_r4_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nbs_wr_engine.sv
// nbs_wr_engine: walks the parameter write table in index order. Each entry
// becomes one request held until acknowledged. A pulse marks each
// acknowledged entry that carries the stage-closing flag.
// Assumes: the table is packed {last, addr, data} per entry, with entry 0
// in the least significant bits.
module nbs_wr_engine #(
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned NENT = 8,
    parameter logic [NENT*(AW+DW+1)-1:0] TABLE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          go,
    input  logic          ack_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          stage_end_o
);
    localparam int unsigned EW = AW + DW + 1;
    localparam int unsigned IW = (NENT > 1) ? $clog2(NENT) : 1;

    logic [IW-1:0] idx_q;
    logic          req_q;
    logic [EW-1:0] ent;

    // Select the current entry and split it into its fields.
    always_comb begin
        ent    = TABLE[EW*int'(idx_q) +: EW];
        addr_o = ent[EW-2 -: AW];
        data_o = ent[DW-1:0];
    end

    assign req_o       = req_q;
    assign stage_end_o = req_q & ack_i & ent[EW-1];

    // Raise the request when enabled; on acknowledge, drop it and advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q <= '0;
            req_q <= 1'b0;
        end else if (req_q && ack_i) begin
            req_q <= 1'b0;
            if (idx_q != IW'(NENT-1)) idx_q <= idx_q + 1'b1;
        end else if (go) begin
            req_q <= 1'b1;
        end
    end

    // R6: a pending request keeps its address and data until acknowledged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));
    // R6: every acknowledge is followed by a cycle with no request.
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_o && ack_i) |=> !req_o);
endmodule

// File: rtl/nic_init_seq.sv
// nic_init_seq: top of the bring-up sequencer. The steps are: hold the chip
// in reset, release it, wait for two interrupt events under a timeout, then
// run five configuration stages from the write table and raise ready.
// Assumes: start_i is a one-cycle pulse; RST_HOLD and IRQ_TMO are at least 1;
// the table holds at least five stage-closing entries.
module nic_init_seq #(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 16,
    parameter int unsigned NENT     = 8,
    parameter int unsigned RST_HOLD = 8,
    parameter int unsigned IRQ_TMO  = 64,
    parameter logic [NENT*(AW+DW+1)-1:0] TABLE = {
        {1'b1, 8'h51, 16'hFFFF}, {1'b0, 8'h50, 16'h0001},
        {1'b1, 8'h41, 16'h5678}, {1'b0, 8'h40, 16'h1234},
        {1'b1, 8'h30, 16'h0003}, {1'b1, 8'h21, 16'h8000},
        {1'b0, 8'h20, 16'h0001}, {1'b1, 8'h10, 16'h00F3}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          irq_n_i,
    input  logic          ack_i,
    output logic          chip_rst_n_o,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          busy_o,
    output logic          ready_o,
    output logic          err_o
);
    import nbs_pkg::*;

    localparam int unsigned TMAX    = (RST_HOLD > IRQ_TMO) ? RST_HOLD : IRQ_TMO;
    localparam int unsigned TW      = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(RST_HOLD - 1);
    localparam logic [TW-1:0] TMO_LD  = TW'(IRQ_TMO - 1);
    localparam logic [2:0]    LAST_STG = 3'(NBS_STAGES - 1);

    nbs_state_t    st_q, st_n;
    logic [2:0]    stg_q, stg_n;
    logic          err_q, err_n;
    logic          t_load, t_dec, t_zero;
    logic [TW-1:0] t_val;
    logic          irq_evt, stage_end;

    nbs_irq_edge u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n_i (irq_n_i),
        .evt_o   (irq_evt)
    );

    nbs_tmr #(.W(TW), .RST_VAL(RST_HOLD - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero_o   (t_zero)
    );

    nbs_wr_engine #(.AW(AW), .DW(DW), .NENT(NENT), .TABLE(TABLE)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (start_i),
        .go          (st_q == ST_CFG),
        .ack_i       (ack_i),
        .req_o       (req_o),
        .addr_o      (addr_o),
        .data_o      (data_o),
        .stage_end_o (stage_end)
    );

    // Next-state logic: a start pulse overrides everything, else step order.
    always_comb begin
        st_n   = st_q;
        stg_n  = stg_q;
        err_n  = err_q;
        t_load = 1'b0;
        t_val  = HOLD_LD;
        t_dec  = 1'b0;
        if (start_i) begin
            st_n   = ST_HOLD;
            stg_n  = '0;
            err_n  = 1'b0;
            t_load = 1'b1;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    if (t_zero) st_n = ST_REL;
                    else        t_dec = 1'b1;
                end
                ST_REL: begin
                    if (chip_rst_n_o) begin
                        st_n   = ST_WOSC;
                        t_load = 1'b1;
                        t_val  = TMO_LD;
                    end
                end
                ST_WOSC: begin
                    if (irq_evt) begin
                        st_n   = ST_WSELF;
                        t_load = 1'b1;
                        t_val  = TMO_LD;
                    end else if (t_zero) begin
                        st_n  = ST_IDLE;
                        err_n = 1'b1;
                    end else begin
                        t_dec = 1'b1;
                    end
                end
                ST_WSELF: begin
                    if (irq_evt) begin
                        st_n  = ST_CFG;
                        stg_n = '0;
                    end else if (t_zero) begin
                        st_n  = ST_IDLE;
                        err_n = 1'b1;
                    end else begin
                        t_dec = 1'b1;
                    end
                end
                ST_CFG: begin
                    if (stage_end) begin
                        if (stg_q == LAST_STG) st_n  = ST_DONE;
                        else                   stg_n = stg_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State, stage index and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            stg_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            stg_q <= stg_n;
            err_q <= err_n;
        end
    end

    assign chip_rst_n_o = (st_q != ST_HOLD);
    assign busy_o       = (st_q != ST_IDLE) && (st_q != ST_DONE);
    assign ready_o      = (st_q == ST_DONE);
    assign err_o        = err_q;

    // R2: the reset line is released only when the hold window has run out.
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_n_o) |-> $past(t_zero));
    // R3: no write request outside the configuration stages.
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CFG) |-> !req_o);
    // R7: ready rises only after the fifth stage's closing acknowledge.
    a_r7_ready_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(stage_end && stg_q == LAST_STG));
    // R4: an error excludes both busy and ready.
    a_r4_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !ready_o));
    // R8: a start pulse puts the chip back into reset and clears the status.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!chip_rst_n_o && !err_o && !ready_o && !req_o));
endmodule

// File: tb/test_nic_init_seq.sv
// test_nic_init_seq: self-checking bench. It mixes random interrupt spacing
// and random acknowledge delays with directed timeout, abort and
// ignored-event cases.
module test_nic_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 8;
    localparam int HOLD = 8;
    localparam int TMO  = 64;
    localparam logic [NENT*25-1:0] TBL = {
        {1'b1, 8'h51, 16'hFFFF}, {1'b0, 8'h50, 16'h0001},
        {1'b1, 8'h41, 16'h5678}, {1'b0, 8'h40, 16'h1234},
        {1'b1, 8'h30, 16'h0003}, {1'b1, 8'h21, 16'h8000},
        {1'b0, 8'h20, 16'h0001}, {1'b1, 8'h10, 16'h00F3}};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, irq_n = 1'b1, ack = 1'b0;
    logic chip_rst_n, req, busy, ready, err;
    logic [7:0]  addr;
    logic [15:0] data;

    int n_cmp = 0, n_bad = 0, nlog = 0;
    bit done = 0;
    logic [7:0]  log_a [0:63];
    logic [15:0] log_d [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_init_seq #(.AW(8), .DW(16), .NENT(NENT), .RST_HOLD(HOLD),
                   .IRQ_TMO(TMO), .TABLE(TBL)) i_nic_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .irq_n_i(irq_n),
        .ack_i(ack), .chip_rst_n_o(chip_rst_n), .req_o(req),
        .addr_o(addr), .data_o(data), .busy_o(busy), .ready_o(ready),
        .err_o(err));

    function automatic logic [7:0] exp_addr(int i);
        logic [24:0] e = TBL[25*i +: 25];
        return e[23:16];
    endfunction
    function automatic logic [15:0] exp_data(int i);
        logic [24:0] e = TBL[25*i +: 25];
        return e[15:0];
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Acknowledge responder: random delay, logs each accepted write (R6, R7).
    initial begin
        int wait_c = 0;
        forever begin
            @(negedge clk);
            if (ack) ack = 1'b0;
            else if (req && rst_n) begin
                if (wait_c == 0) begin
                    chk(ready == 1'b0, "R7", "ready before final ack", int'(ready), 0);
                    if (nlog < 64) begin
                        log_a[nlog] = addr;
                        log_d[nlog] = data;
                    end
                    nlog++;
                    ack = 1'b1;
                    wait_c = int'($urandom % 4);
                end else wait_c--;
            end
        end
    end

    task automatic pulse_irq();
        @(negedge clk); irq_n = 1'b0;
        repeat (3) @(negedge clk);
        irq_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Count cycles with the reset line low, starting at the current negedge.
    task automatic count_hold(string rq);
        int lows = 0;
        while (!chip_rst_n && lows < 100) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == HOLD, rq, "reset line low cycles", lows, HOLD);
    endtask

    // Called once the reset line is high: two interrupts, then the table.
    task automatic run_cfg(int d1, int d2);
        repeat (d1) @(negedge clk);
        chk(req == 1'b0, "R3", "no request before first irq", int'(req), 0);
        pulse_irq();
        repeat (d2) @(negedge clk);
        chk(req == 1'b0 && busy == 1'b1, "R3", "still waiting after one irq",
            int'({busy, req}), 2);
        pulse_irq();
        for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
        chk(ready == 1'b1 && busy == 1'b0, "R7", "ready/busy at end",
            int'({ready, busy}), 2);
        chk(nlog == NENT, "R5", "write count", nlog, NENT);
        for (int i = 0; i < NENT && i < nlog; i++) begin
            chk(log_a[i] == exp_addr(i), "R5", $sformatf("addr of entry %0d", i),
                int'(log_a[i]), int'(exp_addr(i)));
            chk(log_d[i] == exp_data(i), "R5", $sformatf("data of entry %0d", i),
                int'(log_d[i]), int'(exp_data(i)));
        end
        chk(err == 1'b0, "R4", "no error on good run", int'(err), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: state while reset is held.
        chk(chip_rst_n == 1'b0, "R1", "chip reset line", int'(chip_rst_n), 0);
        chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
        chk({ready, err, req} == 3'b000, "R1", "ready/err/req in reset",
            int'({ready, err, req}), 0);
        rst_n = 1'b1;
        count_hold("R2");
        run_cfg(5, 5);

        // R7: ready holds and ignores interrupts.
        pulse_irq();
        repeat (20) @(negedge clk);
        chk(ready == 1'b1 && nlog == NENT, "R7", "ready persists, no writes",
            int'(ready), 1);

        // Random runs restarted by command (R2, R8).
        for (int it = 0; it < 6; it++) begin
            do_start();
            chk(ready == 1'b0 && chip_rst_n == 1'b0, "R8", "restart clears ready",
                int'({ready, chip_rst_n}), 0);
            nlog = 0;
            count_hold("R2");
            run_cfg(int'($urandom % 20), int'($urandom % 20));
        end

        // R4: oscillator wait timeout; R9: error is sticky.
        do_start(); nlog = 0;
        count_hold("R2");
        repeat (TMO - 12) @(negedge clk);
        chk(err == 1'b0 && busy == 1'b1, "R4", "no early timeout",
            int'({err, busy}), 1);
        repeat (20) @(negedge clk);
        chk(err == 1'b1 && busy == 1'b0 && ready == 1'b0, "R4", "osc timeout",
            int'({err, busy, ready}), 4);
        chk(chip_rst_n == 1'b1 && nlog == 0, "R4", "line high, no writes",
            nlog, 0);
        pulse_irq(); pulse_irq();
        repeat (30) @(negedge clk);
        chk(err == 1'b1 && nlog == 0, "R9", "error sticky through irqs",
            int'(err), 1);

        // R4: self-init wait timeout.
        do_start(); nlog = 0;
        chk(err == 1'b0, "R8", "start clears error", int'(err), 0);
        count_hold("R2");
        pulse_irq();
        repeat (TMO + 10) @(negedge clk);
        chk(err == 1'b1 && nlog == 0, "R4", "self-init timeout", int'(err), 1);

        // R3: an interrupt while the reset line is low does not count.
        do_start(); nlog = 0;
        irq_n = 1'b0;
        repeat (3) @(negedge clk);
        irq_n = 1'b1;
        for (int i = 0; i < 20 && !chip_rst_n; i++) @(negedge clk);
        pulse_irq();
        repeat (TMO + 10) @(negedge clk);
        chk(err == 1'b1 && nlog == 0, "R3", "irq during reset ignored",
            int'(err), 1);

        // R8: abort in the middle of configuration, then a full clean run.
        do_start();
        count_hold("R2");
        nlog = 0;
        pulse_irq(); pulse_irq();
        for (int i = 0; i < 200 && nlog < 3; i++) @(negedge clk);
        do_start();
        chk(req == 1'b0 && ready == 1'b0, "R8", "abort withdraws request",
            int'(req), 0);
        @(negedge clk);
        nlog = 0;
        for (int i = 0; i < 20 && !chip_rst_n; i++) @(negedge clk);
        run_cfg(3, 7);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule